// File: doc/BRIEF.md
# Self-Timed Wired-OR Bus Arbitration Cluster

This block resolves bus ownership among several contenders without any central arbiter. Every node carries a fixed identifier of `IDW` bits. When a start strobe opens an arbitration round, each requesting node drives its identifier onto a shared set of arbitration lines, and the lines combine as a wired-OR. Each node then compares, bit by bit from the most significant end, the value it sees on the lines with its own identifier. At the first position where the lines show a 1 and the node's own bit is 0, the node stops driving every bit below that position. Because the decision is recomputed from the node's own identifier every cycle, a node can drive a bit again if the higher line that made it withdraw later goes low. The lines settle on the largest requesting identifier.

The top level holds one node per contender, the wired-OR of their drives, and a sequencer. The sequencer gives the round a fixed settle window of `SETTLE` evaluation cycles, samples the result, and then releases the lines. The winner is reported as a one-hot vector with one bit per node, together with the winning identifier and a one-cycle valid pulse. Identifiers must be distinct and must stay stable while a round is running. `SETTLE` must be at least `IDW - 1`.

Top module: `dist_arb_top`

## Requirements
- R1: After reset `busLines`, `wonVec`, `winId` and `resultValid` are all zero.
- R2: A node whose `reqVec` bit was 0 at the start edge drives no line. A requesting node drives only bits that are 1 in its own identifier, so the edge after start shows the OR of the requesting identifiers on `busLines`.
- R3: During evaluation, a requesting node that sees a line at 1 where its own bit is 0 drives none of the lower-order bits on the next cycle.
- R4: A withdrawn bit is driven again once the higher line that caused the withdrawal drops, so the lines converge to the largest requesting identifier (for example, identifiers 10, 7 and 6 resolve to 10).
- R5: `resultValid` pulses high for exactly one cycle, `SETTLE`+1 clock edges after the edge that accepted `startArb`. In that cycle `winId` equals the largest requesting identifier.
- R6: In the result cycle, `wonVec` is one-hot, with the bit set for the node whose identifier equals `winId`. Node k's identifier is bits [k*IDW +: IDW] of `nodeIds`, and node k owns bit k of `reqVec` and `wonVec`.
- R7: If no node requests, the round still completes with `winId` equal to 0 and `wonVec` equal to 0.
- R8: `startArb` has no effect while a round is in progress: no extra result pulse occurs and the result is unchanged.
- R9: Requests are captured on the start edge. Changes to `reqVec` during a round do not alter its outcome.
- R10: `wonVec` and `winId` hold their values until the next accepted start, which clears them. The lines are released (zero) after sampling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startArb | input | 1 | Opens an arbitration round when the cluster is idle |
| reqVec | input | NODES | Per-node request, sampled at the start edge |
| nodeIds | input | NODES*IDW | Packed per-node identifiers |
| busLines | output | IDW | Wired-OR value of the arbitration lines |
| wonVec | output | NODES | One-hot winner indication |
| winId | output | IDW | Identifier sampled at the end of the settle window |
| resultValid | output | 1 | One-cycle pulse when the result is sampled |

## Verification
Arbitration is run with two requesters whose identifiers share a high bit (6 against 5). This shows that the low-bit compare is what decides between them. A full contention round puts a lone high-bit identifier against several lower ones, which exercises the immediate withdrawal. A single requester and an empty round cover the degenerate outcomes. An identifier set of 10, 7 and 6 makes the winner first withdraw one of its own bits and then drive it again, which separates correct re-assertion from a node that latches its withdrawal. One round toggles the requests and re-pulses start in the middle of the window, which shows that requests are captured once and that a busy cluster ignores start.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EVAL   = 2'd1,
    ST_SAMPLE = 2'd2
  } arbState_e;

  typedef struct packed {
    logic load;    // start accepted: capture request, drive identifier
    logic eval;    // recompute drive against the lines
    logic sample;  // latch winner, release the lines
  } arbStrb_t;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int SETTLE = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startArb,
  output arbStrb_t strb,
  output logic     resultValid
);
  localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  arbState_e state;
  logic [CW-1:0] cnt;

  always_comb begin
    strb.load   = (state == ST_IDLE) && startArb;
    strb.eval   = (state == ST_EVAL);
    strb.sample = (state == ST_SAMPLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strb.sample;
      unique case (state)
        ST_IDLE: if (startArb) begin
          state <= ST_EVAL;
          cnt   <= '0;
        end
        ST_EVAL: if (cnt == LAST) state <= ST_SAMPLE;
                 else cnt <= cnt + 1'b1;
        ST_SAMPLE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EVAL && startArb) |=> (state != ST_IDLE));
endmodule

// File: rtl/arb_node.sv
module arb_node
  import arb_pkg::*;
#(
  parameter int IDW = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  arbStrb_t       strb,
  input  logic           reqIn,
  input  logic [IDW-1:0] myId,
  input  logic [IDW-1:0] busIn,
  output logic [IDW-1:0] driveOut,
  output logic           wonOut
);
  logic           reqHeld;
  logic [IDW-1:0] nextDrive;

  // Compare from MSB down; once a foreign 1 is seen above, lower bits drop.
  always_comb begin
    logic blocked;
    blocked = 1'b0;
    for (int i = IDW - 1; i >= 0; i--) begin
      nextDrive[i] = myId[i] & ~blocked;
      blocked      = blocked | (busIn[i] & ~myId[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqHeld  <= 1'b0;
      driveOut <= '0;
      wonOut   <= 1'b0;
    end else if (strb.load) begin
      reqHeld  <= reqIn;
      driveOut <= reqIn ? myId : '0;
      wonOut   <= 1'b0;
    end else if (strb.eval) begin
      driveOut <= reqHeld ? nextDrive : '0;
    end else if (strb.sample) begin
      wonOut   <= reqHeld && (busIn == myId);
      driveOut <= '0;
      reqHeld  <= 1'b0;
    end
  end

  p_own_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    (driveOut & ~myId) == '0);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !reqIn) |=> (driveOut == '0));
  p_withdraw_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eval && reqHeld && busIn[IDW-1] && !myId[IDW-1])
      |=> (driveOut[IDW-2:0] == '0));
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int NODES = 4,
  parameter int IDW   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  arbStrb_t             strb,
  input  logic [NODES-1:0]     reqVec,
  input  logic [NODES*IDW-1:0] nodeIds,
  output logic [IDW-1:0]       busLines,
  output logic [NODES-1:0]     wonVec,
  output logic [IDW-1:0]       winId
);
  logic [IDW-1:0] drives [NODES];

  for (genvar k = 0; k < NODES; k++) begin : g_node
    arb_node #(.IDW(IDW)) uNode (
      .clk     (clk),
      .rstN    (rstN),
      .strb    (strb),
      .reqIn   (reqVec[k]),
      .myId    (nodeIds[k*IDW +: IDW]),
      .busIn   (busLines),
      .driveOut(drives[k]),
      .wonOut  (wonVec[k])
    );
  end

  // Wired-OR of all node drives.
  always_comb begin
    busLines = '0;
    for (int k = 0; k < NODES; k++) busLines = busLines | drives[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            winId <= '0;
    else if (strb.load)   winId <= '0;
    else if (strb.sample) winId <= busLines;
  end

  p_one_winner_r6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(wonVec) <= 1);
  p_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.sample |=> (busLines == '0));
endmodule

// File: rtl/dist_arb_top.sv
module dist_arb_top
  import arb_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int IDW    = 4,
  parameter int SETTLE = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startArb,
  input  logic [NODES-1:0]     reqVec,
  input  logic [NODES*IDW-1:0] nodeIds,
  output logic [IDW-1:0]       busLines,
  output logic [NODES-1:0]     wonVec,
  output logic [IDW-1:0]       winId,
  output logic                 resultValid
);
  arbStrb_t strb;

  arb_ctrl #(.SETTLE(SETTLE)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startArb   (startArb),
    .strb       (strb),
    .resultValid(resultValid)
  );

  arb_datapath #(.NODES(NODES), .IDW(IDW)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqVec  (reqVec),
    .nodeIds (nodeIds),
    .busLines(busLines),
    .wonVec  (wonVec),
    .winId   (winId)
  );
endmodule

// File: tb/sim_dist_arb_top.sv
module sim_dist_arb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NODES  = 4;
  localparam int IDW    = 4;
  localparam int SETTLE = 4;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 startArb = 1'b0;
  logic [NODES-1:0]     reqVec = '0;
  logic [NODES*IDW-1:0] nodeIds = '0;
  logic [IDW-1:0]       busLines;
  logic [NODES-1:0]     wonVec;
  logic [IDW-1:0]       winId;
  logic                 resultValid;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  typedef struct {
    logic [IDW-1:0]   expId;
    logic [NODES-1:0] expWon;
    int               dueCyc;
  } item_t;
  item_t sbq[$];

  dist_arb_top #(.NODES(NODES), .IDW(IDW), .SETTLE(SETTLE)) u0 (
    .clk(clk), .rstN(rstN), .startArb(startArb), .reqVec(reqVec),
    .nodeIds(nodeIds), .busLines(busLines), .wonVec(wonVec),
    .winId(winId), .resultValid(resultValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected results as the design produces them.
  always @(negedge clk) begin
    if (rstN && resultValid) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R8 unexpected result pulse", 32'(winId), 32'hFFFF);
      end else begin
        item_t it;
        it = sbq.pop_front();
        check(winId == it.expId, "R5 winId", 32'(winId), 32'(it.expId));
        check(wonVec == it.expWon, "R6 wonVec", 32'(wonVec), 32'(it.expWon));
        check(cyc == it.dueCyc, "R5 result timing", 32'(cyc), 32'(it.dueCyc));
      end
    end
  end

  // Driver: computes expectation from requirements, pushes, then runs the round.
  task automatic runArb(input logic [NODES-1:0] req,
                        input logic [NODES*IDW-1:0] ids, input bit disturb);
    item_t it;
    logic [IDW-1:0] mx;
    logic [IDW-1:0] orIds;
    mx = '0; orIds = '0;
    for (int k = 0; k < NODES; k++)
      if (req[k]) begin
        orIds = orIds | ids[k*IDW +: IDW];
        if (ids[k*IDW +: IDW] > mx) mx = ids[k*IDW +: IDW];
      end
    it.expId = mx;
    it.expWon = '0;
    for (int k = 0; k < NODES; k++)
      if (req[k] && ids[k*IDW +: IDW] == mx) it.expWon[k] = 1'b1;
    @(negedge clk);
    nodeIds = ids;
    reqVec = req;
    startArb = 1'b1;
    it.dueCyc = cyc + SETTLE + 2;
    sbq.push_back(it);
    @(negedge clk);
    startArb = 1'b0;
    check(wonVec == '0, "R10 won cleared at start", 32'(wonVec), 0);
    check(busLines == orIds, "R2 initial lines", 32'(busLines), 32'(orIds));
    if (disturb) begin
      reqVec = ~req;      // R9: must not affect this round
      startArb = 1'b1;    // R8: ignored while busy
      @(negedge clk);
      startArb = 1'b0;
    end
    while (sbq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(wonVec == it.expWon, "R10 won held", 32'(wonVec), 32'(it.expWon));
    check(winId == mx, "R10 winId held", 32'(winId), 32'(mx));
    check(busLines == '0, "R10 lines released", 32'(busLines), 0);
  endtask

  initial begin
    logic [NODES*IDW-1:0] idsA;
    logic [NODES*IDW-1:0] idsB;
    idsA = {4'd9, 4'd3, 4'd6, 4'd5};   // node3..node0
    idsB = {4'd1, 4'd6, 4'd7, 4'd10};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busLines == '0, "R1 lines", 32'(busLines), 0);
    check(wonVec == '0, "R1 won", 32'(wonVec), 0);
    check(winId == '0, "R1 winId", 32'(winId), 0);
    check(resultValid == 1'b0, "R1 valid", 32'(resultValid), 0);

    runArb(4'b0011, idsA, 1'b0);  // 6 beats 5 (R3, R5, R6)
    runArb(4'b1111, idsA, 1'b0);  // lone high bit wins
    runArb(4'b0100, idsA, 1'b0);  // R2: non-requester id 9 absent
    runArb(4'b0000, idsA, 1'b0);  // R7: nobody requests
    runArb(4'b0111, idsB, 1'b0);  // R4: 10 withdraws bit1 then re-asserts
    runArb(4'b0011, idsA, 1'b1);  // R8, R9: disturbance mid-window
    runArb(4'b1010, idsB, 1'b0);  // R3: 7 vs 1

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule